// File: doc/BRIEF.md
# Three-Phase Line Voltage Sag Detector

This block watches the line voltage of three phases for a sag, meaning a sustained dip in amplitude. An upstream stage produces, once per half-line cycle for each phase, an amplitude measure and a strobe that marks it as valid. The detector compares each new amplitude against one shared level. It counts how many half-cycles in a row have stayed below that level. When the run reaches a programmed length, it raises a one-clock sag event for that phase. Interrupt status logic can latch this event and use it to drive an interrupt line.

Two small configuration registers hold the settings, and all three phases share them. One holds the sag level. The other holds the number of consecutive low half-cycles needed to declare a sag. Writing either register starts every phase's run count again from zero. A single low half-cycle never raises an event unless the required run length is one.

Top module: `vsag_monitor`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the level register holds 0, the run-length register holds 0xFF, every run count is 0 and every sag_event bit is 0.
- R2: A phase strobe whose amplitude is below the level increments that phase's run count by one. The comparison is unsigned and strict.
- R3: A phase strobe whose amplitude is equal to or above the level returns that phase's run count to zero.
- R4: A strobe that brings the run count up to the required length raises that phase's sag_event bit. The bit is high for exactly one clock, in the cycle after the edge that sampled the strobe. The count then saturates, so further low strobes raise no more events until the run is broken.
- R5: A run-length value of 0 acts as 1: the first low strobe raises the event.
- R6: With the level at 0, no amplitude is below it, so no event is ever raised.
- R7: A write to either register sets all three run counts to zero. A strobe in the same cycle as the write is discarded, and the new value governs from the next cycle.
- R8: The phases are independent of each other and share only the two registers. A strobe on one phase never changes another phase's count or event.
- R9: In a cycle with no strobe and no register write, a phase's run count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| half_done | input | NUM_PH | Per-phase strobe marking a valid half-cycle amplitude |
| amp_in | input | NUM_PH*AMP_W | Amplitudes packed side by side; phase p is in bits [p*AMP_W +: AMP_W] |
| lvl_we | input | 1 | Write enable for the sag level register |
| lvl_wdata | input | AMP_W | New sag level |
| cyc_we | input | 1 | Write enable for the run-length register |
| cyc_wdata | input | CNT_W | New required run length in half-cycles |
| sag_event | output | NUM_PH | One-clock sag event per phase |

## Verification
On every cycle, assertions check how the run counter moves. It stays within the effective target. It steps up by exactly one on a low strobe, drops to zero on a high strobe or a register write, and holds when nothing happens. The assertions also check that an event lasts one clock, appears only with the counter at its target, and never follows a level of zero. They cannot show that the event comes on the right strobe of a long run. Nor can they show that the 0xFF reset length really needs 255 low half-cycles, or that the phases stay independent under mixed traffic. The bench shows these through directed runs and a seeded random sequence, which it compares against a reference model.

// File: rtl/vsag_pkg.sv
// Package: vsag_pkg
// Shared widths, reset values and types for the three-phase sag detector.
// Assumes amplitudes and run lengths are unsigned.
package vsag_pkg;
    localparam int unsigned DEF_PHASES = 3;
    localparam int unsigned DEF_AMP_W  = 8;
    localparam int unsigned DEF_CNT_W  = 8;

    // Decoded view of the shared settings, as seen by every phase tracker.
    typedef struct packed {
        logic [DEF_AMP_W-1:0] level;
        logic [DEF_CNT_W-1:0] target;
    } vsag_cfg_t;
endpackage

// File: rtl/vsag_cfg_regs.sv
// Module: vsag_cfg_regs
// Holds the shared sag level and the required run length. Produces an
// effective target in which a length of 0 is raised to 1, plus a pulse that
// clears every run count. Assumes the write strobes are synchronous to clk.
module vsag_cfg_regs #(
    parameter int unsigned AMP_W = 8,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_we,
    input  logic [AMP_W-1:0] lvl_wdata,
    input  logic             cyc_we,
    input  logic [CNT_W-1:0] cyc_wdata,
    output logic [AMP_W-1:0] level_q,
    output logic [CNT_W-1:0] cyc_q,
    output logic [CNT_W-1:0] target_q,
    output logic             run_clear
);
    localparam logic [CNT_W-1:0] CYC_RESET = '1;
    localparam logic [AMP_W-1:0] LVL_RESET = '0;
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    // Level register: reset to zero, loaded on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      level_q <= LVL_RESET;
        else if (lvl_we) level_q <= lvl_wdata;
    end

    // Run-length register and its effective target (a length of zero acts as one).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q    <= CYC_RESET;
            target_q <= CYC_RESET;
        end else if (cyc_we) begin
            cyc_q    <= cyc_wdata;
            target_q <= (cyc_wdata == '0) ? ONE : cyc_wdata;
        end
    end

    // Any write to either register restarts all runs.
    always_comb run_clear = lvl_we | cyc_we;

    // R1: reset values of the shared registers
    a_r1_cfg_reset: assert property (@(posedge clk)
        !rst_n |=> (level_q == LVL_RESET && cyc_q == CYC_RESET));
    // R5: the effective target is never zero
    a_r5_target_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        target_q != '0);
    // R7: a written run length appears in the register on the next cycle
    a_r7_cyc_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_we |=> cyc_q == $past(cyc_wdata));
    // R7: a written level appears in the register on the next cycle
    a_r7_lvl_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_we |=> level_q == $past(lvl_wdata));
endmodule

// File: rtl/vsag_phase_track.sv
// Module: vsag_phase_track
// Per-phase tracker for consecutive half-cycles below the level. The count
// rises on each low strobe, saturates at the target, and drops to zero on a
// high strobe or on run_clear. Raises a one-clock event when the count reaches
// the target. Assumes target is never zero.
module vsag_phase_track #(
    parameter int unsigned AMP_W = 8,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [AMP_W-1:0] amp,
    input  logic [AMP_W-1:0] level,
    input  logic [CNT_W-1:0] target,
    input  logic             run_clear,
    output logic             sag_pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] run_inc;
    logic             below;
    logic             room;
    logic             hit;

    // Compare the amplitude with the level and work out whether this strobe completes a run.
    always_comb begin
        below   = amp < level;
        room    = run_cnt < target;
        run_inc = run_cnt + ONE;
        hit     = strobe && below && room && (run_inc == target) && !run_clear;
    end

    // Run counter: clear, saturating increment, or reset on a high half-cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_cnt <= '0;
        else if (run_clear) run_cnt <= '0;
        else if (strobe) begin
            if (!below)     run_cnt <= '0;
            else if (room)  run_cnt <= run_inc;
        end
    end

    // Registered one-clock sag event.
    always_ff @(posedge clk) begin
        if (!rst_n) sag_pulse <= 1'b0;
        else        sag_pulse <= hit;
    end

    // R4: the count never goes past the target
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= target);
    // R2: a low strobe below the target steps the count by one
    a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && below && room && !run_clear) |=> run_cnt == $past(run_cnt) + ONE);
    // R3: a strobe at or above the level empties the run
    a_r3_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !below) |=> run_cnt == '0);
    // R7: a register write empties the run
    a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        run_clear |=> run_cnt == '0);
    // R9: no strobe and no write leaves the count alone
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !run_clear) |=> $stable(run_cnt));
    // R4: the event lasts exactly one clock
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sag_pulse |=> !sag_pulse);
    // R4: the event only appears with the count sitting at the target
    a_r4_pulse_at_target: assert property (@(posedge clk) disable iff (!rst_n)
        sag_pulse |-> run_cnt == target);
    // R6: no event follows a cycle in which the level was zero
    a_r6_level_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |=> !sag_pulse);
endmodule

// File: rtl/vsag_monitor.sv
// Module: vsag_monitor
// Top of the three-phase sag detector. One configuration block is shared by
// all phases, and a generate loop builds one tracker per phase. Assumes each
// phase's amplitude is valid in the cycle its half_done bit is high.
module vsag_monitor #(
    parameter int unsigned NUM_PH = vsag_pkg::DEF_PHASES,
    parameter int unsigned AMP_W  = vsag_pkg::DEF_AMP_W,
    parameter int unsigned CNT_W  = vsag_pkg::DEF_CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_PH-1:0]       half_done,
    input  logic [NUM_PH*AMP_W-1:0] amp_in,
    input  logic                    lvl_we,
    input  logic [AMP_W-1:0]        lvl_wdata,
    input  logic                    cyc_we,
    input  logic [CNT_W-1:0]        cyc_wdata,
    output logic [NUM_PH-1:0]       sag_event
);
    logic [AMP_W-1:0] level_q;
    logic [CNT_W-1:0] cyc_q;
    logic [CNT_W-1:0] target_q;
    logic             run_clear;

    vsag_cfg_regs #(.AMP_W(AMP_W), .CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_we    (lvl_we),
        .lvl_wdata (lvl_wdata),
        .cyc_we    (cyc_we),
        .cyc_wdata (cyc_wdata),
        .level_q   (level_q),
        .cyc_q     (cyc_q),
        .target_q  (target_q),
        .run_clear (run_clear)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        vsag_phase_track #(.AMP_W(AMP_W), .CNT_W(CNT_W)) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .strobe    (half_done[p]),
            .amp       (amp_in[p*AMP_W +: AMP_W]),
            .level     (level_q),
            .target    (target_q),
            .run_clear (run_clear),
            .sag_pulse (sag_event[p])
        );
    end

    // R8: an event on a phase needs a strobe on that same phase one cycle earlier
    a_r8_event_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (sag_event & ~$past(half_done)) == '0);
    // R7: a register write is never followed by an event
    a_r7_no_event_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_we || cyc_we) |=> sag_event == '0);
endmodule

// File: tb/vsag_monitor_test.sv
module vsag_monitor_test;
    localparam int NP = 3;
    localparam int AW = 8;
    localparam int CW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     half_done = '0;
    logic [NP*AW-1:0]  amp_in = '0;
    logic              lvl_we = 1'b0;
    logic [AW-1:0]     lvl_wdata = '0;
    logic              cyc_we = 1'b0;
    logic [CW-1:0]     cyc_wdata = '0;
    logic [NP-1:0]     sag_event;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference model state
    int m_level = 0;
    int m_cyc   = 255;
    int m_cnt [NP];

    vsag_monitor #(.NUM_PH(NP), .AMP_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .half_done(half_done), .amp_in(amp_in),
        .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .cyc_we(cyc_we),
        .cyc_wdata(cyc_wdata), .sag_event(sag_event)
    );

    always #10 clk = ~clk;

    function automatic int eff_target(int c);
        return (c == 0) ? 1 : c;
    endfunction

    // Advance the model by one clock and return the expected event bits.
    function automatic logic [NP-1:0] model_step(logic [NP-1:0] stb, logic [NP*AW-1:0] a,
                                                 bit wl, int dl, bit wc, int dc);
        logic [NP-1:0] ev = '0;
        if (wl || wc) begin
            if (wl) m_level = dl;
            if (wc) m_cyc = dc;
            for (int p = 0; p < NP; p++) m_cnt[p] = 0;
            return ev;
        end
        for (int p = 0; p < NP; p++) begin
            if (stb[p]) begin
                if (int'(a[p*AW +: AW]) < m_level) begin
                    if (m_cnt[p] < eff_target(m_cyc)) begin
                        m_cnt[p]++;
                        if (m_cnt[p] == eff_target(m_cyc)) ev[p] = 1'b1;
                    end
                end else begin
                    m_cnt[p] = 0;
                end
            end
        end
        return ev;
    endfunction

    task automatic check(string tag, logic [NP-1:0] got, logic [NP-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: sag_event got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, let the rising edge pass, then compare.
    task automatic step(string tag, logic [NP-1:0] stb, logic [AW-1:0] a0, logic [AW-1:0] a1,
                        logic [AW-1:0] a2, bit wl = 0, int dl = 0, bit wc = 0, int dc = 0);
        logic [NP-1:0] exp;
        half_done = stb;
        amp_in    = {a2, a1, a0};
        lvl_we    = wl;
        lvl_wdata = AW'(dl);
        cyc_we    = wc;
        cyc_wdata = CW'(dc);
        exp = model_step(stb, {a2, a1, a0}, wl, dl, wc, dc);
        @(posedge clk);
        @(negedge clk);
        half_done = '0;
        lvl_we    = 1'b0;
        cyc_we    = 1'b0;
        check(tag, sag_event, exp);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        for (int p = 0; p < NP; p++) m_cnt[p] = 0;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: no event straight out of reset
        check("R1 reset", sag_event, '0);

        // R1 / R6: reset level is 0, so even amplitude 0 never sags
        for (int i = 0; i < 300; i++) step("R6 level zero", 3'b111, 8'd0, 8'd0, 8'd0);

        // R1: reset run length 0xFF needs 255 low half-cycles
        step("R7 write level", 3'b000, 0, 0, 0, 1, 100);
        for (int i = 0; i < 256; i++) step("R1 length 0xFF", 3'b001, 8'd50, 8'd0, 8'd0);

        // R2 / R3 / R4: run of 3 broken by an equal amplitude, then saturation
        step("R7 write length", 3'b000, 0, 0, 0, 0, 0, 1, 3);
        step("R2 low", 3'b001, 8'd99, 8'd0, 8'd0);
        step("R2 low", 3'b001, 8'd10, 8'd0, 8'd0);
        step("R3 equal breaks run", 3'b001, 8'd100, 8'd0, 8'd0);
        step("R2 low", 3'b001, 8'd0, 8'd0, 8'd0);
        step("R2 low", 3'b001, 8'd0, 8'd0, 8'd0);
        step("R4 third low fires", 3'b001, 8'd0, 8'd0, 8'd0);
        for (int i = 0; i < 5; i++) step("R4 saturated no repeat", 3'b001, 8'd0, 8'd0, 8'd0);

        // R9: gaps without strobes keep the count
        step("R3 break", 3'b001, 8'd200, 8'd0, 8'd0);
        step("R2 low", 3'b001, 8'd1, 8'd0, 8'd0);
        for (int i = 0; i < 4; i++) step("R9 hold", 3'b000, 8'd1, 8'd0, 8'd0);
        step("R2 low", 3'b001, 8'd1, 8'd0, 8'd0);
        step("R9 fires after gap", 3'b001, 8'd1, 8'd0, 8'd0);

        // R7: a write mid-run restarts it, and a same-cycle strobe is dropped
        step("R2 low", 3'b010, 8'd0, 8'd5, 8'd0);
        step("R2 low", 3'b010, 8'd0, 8'd5, 8'd0);
        step("R7 write with strobe", 3'b010, 8'd0, 8'd5, 8'd0, 1, 100);
        step("R7 restart 1", 3'b010, 8'd0, 8'd5, 8'd0);
        step("R7 restart 2", 3'b010, 8'd0, 8'd5, 8'd0);
        step("R7 restart 3 fires", 3'b010, 8'd0, 8'd5, 8'd0);

        // R5: length 0 behaves as 1
        step("R7 write length 0", 3'b000, 0, 0, 0, 0, 0, 1, 0);
        step("R5 first low fires", 3'b100, 8'd0, 8'd0, 8'd7);
        step("R5 no repeat", 3'b100, 8'd0, 8'd0, 8'd7);

        // R8: phases independent
        step("R7 write length 2", 3'b000, 0, 0, 0, 0, 0, 1, 2);
        step("R8 mixed", 3'b111, 8'd1, 8'd150, 8'd2);
        step("R8 mixed", 3'b011, 8'd1, 8'd3, 8'd2);
        step("R8 mixed", 3'b111, 8'd1, 8'd3, 8'd2);

        // R8: seeded random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [NP-1:0] stb;
            logic [AW-1:0] a [NP];
            bit wl, wc;
            int dl, dc;
            stb = NP'($urandom);
            for (int p = 0; p < NP; p++) begin
                if ($urandom_range(0, 3) == 0) a[p] = AW'($urandom);
                else a[p] = AW'(m_level + $urandom_range(0, 20) - 12);
            end
            wl = ($urandom_range(0, 59) == 0);
            wc = ($urandom_range(0, 59) == 0);
            dl = $urandom_range(0, 255);
            dc = $urandom_range(0, 6);
            step("R8 random", stb, a[0], a[1], a[2], wl, dl, wc, dc);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule